// File: doc/BRIEF.md
# Sample Minimum, Maximum and Weighted-Average Tracker

This block observes a stream of signed 12-bit conversion results. Each result arrives with a one-cycle valid strobe. The block keeps three statistics in 16-bit arithmetic:

- the running minimum of the samples,
- the running maximum of the samples,
- an exponentially weighted running average, in which each new sample carries a weight of 1/128.

A separate clear input empties the minimum and maximum trackers and leaves the average alone.

The statistics are not exposed as they change. A slow refresh strobe, about once per second in a real system, copies the internal values into output registers. The same strobe raises a one-cycle update pulse. Downstream logic, such as a display path, therefore sees a stable snapshot between refreshes.

Top module: `sample_stat_tracker`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `min_o`, `max_o` and `avg_o` are 0, `update_o` is 0, the internal average is 0 and the minimum and maximum trackers are empty.
- R2: `sample_i` is a 12-bit two's-complement value sign-extended to 16 bits: 12'h800 reads as -2048 and 12'h7FF reads as +2047.
- R3: Samples are compared as signed values. The minimum holds the smallest and the maximum the largest sample accepted since the trackers were last emptied, so the minimum never exceeds the maximum.
- R4: The first accepted sample after a reset or a clear sets both the minimum and the maximum to that sample.
- R5: Each accepted sample x replaces the average a with floor((x + 127·a) / 128). The floor rounds toward minus infinity for negative values.
- R6: `mm_clear_i` empties the minimum and maximum trackers and leaves the average unchanged.
- R7: When `mm_clear_i` and `sample_valid_i` are both high in the same cycle, that sample becomes the first sample after the clear.
- R8: On a clock edge where `refresh_i` is high, the outputs take the statistics as they stood before that edge. A sample accepted on the same edge is not included. `update_o` is high for exactly the one cycle that follows such an edge.
- R9: Between refresh edges, `min_o`, `max_o` and `avg_o` hold their values whatever samples arrive.
- R10: A refresh taken while the trackers are empty reports 0 on both `min_o` and `max_o`.
- R11: A value on `sample_i` without `sample_valid_i` changes no statistic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 12 | Signed conversion result |
| sample_valid_i | input | 1 | Sample strobe, one cycle per result |
| mm_clear_i | input | 1 | Empties the minimum and maximum trackers |
| refresh_i | input | 1 | Slow refresh strobe for the output snapshot |
| min_o | output | 16 | Snapshot of the running minimum |
| max_o | output | 16 | Snapshot of the running maximum |
| avg_o | output | 16 | Snapshot of the weighted average |
| update_o | output | 1 | One-cycle pulse after each snapshot |

## Verification
The bench uses the default parameters: a 12-bit input, 16-bit statistics and a 7-bit averaging shift. With these values it can drive the full signed input range, including -2048 and +2047, through both trackers. Long runs of constant positive and negative inputs let the average settle to the point where floor rounding halts it. Checking those settled values confirms the rounding direction against the recursion in R5. Samples placed on the same edge as a refresh or a clear expose the ordering rules in R7 and R8.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STAT_W = 16;
  typedef logic signed [STAT_W-1:0] stat_t;

  typedef struct packed {
    stat_t min_v;
    stat_t max_v;
    stat_t avg_v;
  } stat_bundle_t;
endpackage

// File: rtl/stat_sext.sv
module stat_sext #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_W-1:0] out_o
);
  localparam int PAD_W = OUT_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign out_o = {{PAD_W{in_i[IN_W-1]}}, in_i};
    end else begin : g_pass
      assign out_o = in_i[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/stat_minmax.sv
module stat_minmax
  import stat_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t x_i,
  input  logic  valid_i,
  input  logic  clear_i,
  output stat_t min_o,
  output stat_t max_o,
  output logic  empty_o
);
  stat_t min_q, max_q;
  logic  empty_q;
  logic  fresh;

  // a sample arriving with clear starts the new window
  assign fresh = empty_q || clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q   <= '0;
      max_q   <= '0;
      empty_q <= 1'b1;
    end else if (valid_i) begin
      empty_q <= 1'b0;
      if (fresh || (x_i < min_q)) min_q <= x_i;
      if (fresh || (x_i > max_q)) max_q <= x_i;
    end else if (clear_i) begin
      empty_q <= 1'b1;
    end
  end

  assign min_o   = min_q;
  assign max_o   = max_q;
  assign empty_o = empty_q;

  assert_min_le_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_q |-> (min_q <= max_q));

  assert_first_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (empty_q || clear_i)) |=> (min_q == $past(x_i)) && (max_q == $past(x_i)));

  assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !valid_i) |=> empty_q);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> $stable(min_q) && $stable(max_q) && $stable(empty_q));
endmodule

// File: rtl/stat_ewma.sv
module stat_ewma
  import stat_pkg::*;
#(
  parameter int SHIFT = 7
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t x_i,
  input  logic  valid_i,
  output stat_t avg_o
);
  localparam int DIFF_W = STAT_W + 1;

  stat_t avg_q;
  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] step;
  logic signed [DIFF_W-1:0] sum;

  // floor((x + (2^S-1)*a) / 2^S) == a + floor((x - a) / 2^S)
  assign diff = DIFF_W'(x_i) - DIFF_W'(avg_q);
  assign step = diff >>> SHIFT;
  assign sum  = DIFF_W'(avg_q) + step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      avg_q <= '0;
    else if (valid_i) avg_q <= sum[STAT_W-1:0];
  end

  assign avg_o = avg_q;

  assert_avg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(avg_q));

  assert_avg_fixed_point_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (x_i == avg_q)) |=> $stable(avg_q));

  assert_avg_direction_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (x_i > avg_q)) |=> (avg_q >= $past(avg_q)));
endmodule

// File: rtl/stat_snapshot.sv
module stat_snapshot
  import stat_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         refresh_i,
  input  stat_bundle_t live_i,
  input  logic         empty_i,
  output stat_bundle_t snap_o,
  output logic         update_o
);
  stat_bundle_t snap_q;
  stat_bundle_t capt;
  logic         upd_q;

  always_comb begin
    capt = live_i;
    if (empty_i) begin
      capt.min_v = '0;
      capt.max_v = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= refresh_i;
      if (refresh_i) snap_q <= capt;
    end
  end

  assign snap_o   = snap_q;
  assign update_o = upd_q;

  assert_pulse_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> update_o);

  assert_no_stray_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_i |=> !update_o);

  assert_hold_between_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refresh_i |=> $stable(snap_q));

  assert_empty_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i && empty_i) |=> (snap_q.min_v == '0) && (snap_q.max_v == '0));
endmodule

// File: rtl/sample_stat_tracker.sv
module sample_stat_tracker
  import stat_pkg::*;
#(
  parameter int IN_W      = 12,
  parameter int AVG_SHIFT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IN_W-1:0]   sample_i,
  input  logic              sample_valid_i,
  input  logic              mm_clear_i,
  input  logic              refresh_i,
  output logic [STAT_W-1:0] min_o,
  output logic [STAT_W-1:0] max_o,
  output logic [STAT_W-1:0] avg_o,
  output logic              update_o
);
  logic [STAT_W-1:0] x_ext;
  stat_t        x_s, min_l, max_l, avg_l;
  logic         empty_l;
  stat_bundle_t live, snap;

  stat_sext #(.IN_W(IN_W), .OUT_W(STAT_W)) u_sext (
    .in_i  (sample_i),
    .out_o (x_ext)
  );

  assign x_s = stat_t'(x_ext);

  stat_minmax u_minmax (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .x_i     (x_s),
    .valid_i (sample_valid_i),
    .clear_i (mm_clear_i),
    .min_o   (min_l),
    .max_o   (max_l),
    .empty_o (empty_l)
  );

  stat_ewma #(.SHIFT(AVG_SHIFT)) u_ewma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .x_i     (x_s),
    .valid_i (sample_valid_i),
    .avg_o   (avg_l)
  );

  assign live.min_v = min_l;
  assign live.max_v = max_l;
  assign live.avg_v = avg_l;

  stat_snapshot u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .refresh_i (refresh_i),
    .live_i    (live),
    .empty_i   (empty_l),
    .snap_o    (snap),
    .update_o  (update_o)
  );

  assign min_o = snap.min_v;
  assign max_o = snap.max_v;
  assign avg_o = snap.avg_v;

  assert_sext_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_s >= -stat_t'(2**(IN_W-1))) && (x_s <= stat_t'(2**(IN_W-1) - 1)));
endmodule

// File: tb/sample_stat_tracker_test.sv
module sample_stat_tracker_test;
  localparam int CLK_HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sample = '0;
  logic        valid = 1'b0;
  logic        clr = 1'b0;
  logic        refresh = 1'b0;
  logic [15:0] min_o, max_o, avg_o;
  logic        update_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_min, m_max, m_avg;
  bit m_empty;

  always #(CLK_HALF) clk = ~clk;

  sample_stat_tracker uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sample_i       (sample),
    .sample_valid_i (valid),
    .mm_clear_i     (clr),
    .refresh_i      (refresh),
    .min_o          (min_o),
    .max_o          (max_o),
    .avg_o          (avg_o),
    .update_o       (update_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)",
               req, $signed(act), act, $signed(exp), exp);
    end
  endtask

  function automatic void model_sample(input int x, input bit with_clear);
    if (m_empty || with_clear) begin
      m_min = x;
      m_max = x;
    end else begin
      if (x < m_min) m_min = x;
      if (x > m_max) m_max = x;
    end
    m_empty = 1'b0;
    m_avg = (x + 127 * m_avg) >>> 7;
  endfunction

  task automatic send(input int x);
    @(negedge clk);
    sample = 12'(x);
    valid  = 1'b1;
    @(negedge clk);
    valid  = 1'b0;
    model_sample(x, 1'b0);
  endtask

  // refresh, then check the snapshot and the pulse
  task automatic snap_check(input string req);
    @(negedge clk);
    refresh = 1'b1;
    @(negedge clk);
    refresh = 1'b0;
    chk({req, " update_o"}, 16'(update_o), 16'd1);
    chk({req, " min_o"}, min_o, m_empty ? 16'd0 : 16'(m_min));
    chk({req, " max_o"}, max_o, m_empty ? 16'd0 : 16'(m_max));
    chk({req, " avg_o"}, avg_o, 16'(m_avg));
    @(negedge clk);
    chk({req, " update_o drop R8"}, 16'(update_o), 16'd0);
  endtask

  task automatic t_reset;
    chk("R1 min", min_o, 16'd0);
    chk("R1 max", max_o, 16'd0);
    chk("R1 avg", avg_o, 16'd0);
    chk("R1 update", 16'(update_o), 16'd0);
    snap_check("R10 empty after reset");
  endtask

  task automatic t_first;
    send(100);
    snap_check("R4 first sample");
  endtask

  task automatic t_signed;
    send(-2048);
    send(2047);
    send(-5);
    snap_check("R2 R3 signed extremes");
    chk("R2 min -2048", min_o, 16'hF800);
    chk("R2 max 2047", max_o, 16'h07FF);
  endtask

  task automatic t_ignore;
    logic [15:0] a0, b0, c0;
    a0 = min_o; b0 = max_o; c0 = avg_o;
    @(negedge clk);
    sample = 12'h800;
    repeat (5) @(negedge clk);
    sample = 12'h7FF;
    repeat (5) @(negedge clk);
    chk("R11 min held", min_o, a0);
    chk("R11 max held", max_o, b0);
    chk("R11 avg held", avg_o, c0);
    snap_check("R11 invalid samples ignored");
  endtask

  task automatic t_hold;
    logic [15:0] a0, b0, c0;
    a0 = min_o; b0 = max_o; c0 = avg_o;
    send(-1000);
    send(1500);
    send(1700);
    chk("R9 min held", min_o, a0);
    chk("R9 max held", max_o, b0);
    chk("R9 avg held", avg_o, c0);
    snap_check("R9 after refresh");
  endtask

  task automatic t_clear;
    int avg_before;
    avg_before = m_avg;
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_empty = 1'b1;
    snap_check("R10 R6 after clear");
    chk("R6 avg kept", avg_o, 16'(avg_before));
    send(7);
    send(9);
    snap_check("R4 first after clear");
    chk("R4 min 7", min_o, 16'd7);
  endtask

  task automatic t_clear_valid;
    send(1200);
    @(negedge clk);
    sample = 12'(-300);
    valid  = 1'b1;
    clr    = 1'b1;
    @(negedge clk);
    valid  = 1'b0;
    clr    = 1'b0;
    model_sample(-300, 1'b1);
    snap_check("R7 clear with sample");
    chk("R7 max -300", max_o, 16'(-300));
  endtask

  task automatic t_same_edge;
    int old_max;
    old_max = m_max;
    @(negedge clk);
    sample  = 12'd2000;
    valid   = 1'b1;
    refresh = 1'b1;
    @(negedge clk);
    valid   = 1'b0;
    refresh = 1'b0;
    chk("R8 pre-edge max", max_o, 16'(old_max));
    chk("R8 pulse", 16'(update_o), 16'd1);
    model_sample(2000, 1'b0);
    @(negedge clk);
    snap_check("R8 sample in next refresh");
  endtask

  task automatic t_converge;
    for (int i = 0; i < 400; i++) send(1500);
    snap_check("R5 settle positive");
    for (int i = 0; i < 400; i++) send(-1800);
    snap_check("R5 settle negative");
    send(-1);
    snap_check("R5 single step");
  endtask

  initial begin
    m_min = 0; m_max = 0; m_avg = 0; m_empty = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", avg_o, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_signed();
    t_ignore();
    t_hold();
    t_clear();
    t_clear_valid();
    t_same_edge();
    t_converge();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule